// File: doc/BRIEF.md
# Compressed Frame Descriptor Ring Engine

This block is the hardware half of a circular ring of status/command words that software and a frame capture or playback engine share for compressed-frame buffers. Software hands a ring entry to hardware by writing a pointer whose bit 0 is clear. The pointer names a two-word buffer descriptor. The engine walks the ring in order. For each owned entry it fetches the descriptor, holds the buffer address and capacity for the data mover, and waits for that mover to report a finished field.

On each finished field the engine writes a completion word back into the ring entry. That word returns ownership, carries an 8-bit frame count and holds the transferred size clipped to the buffer capacity. The engine latches a report interrupt and then moves to the next entry. If no buffer is ready when a field finishes, the engine counts a missed frame and writes nothing. In paired mode each buffer covers two fields. Two consecutive entries share one descriptor, and only even slots start a buffer.

All memory traffic goes through one word-addressed port. A read request returns its data on the following cycle.

Top module: `fdr_engine`

## Requirements
- R1: After reset, `ring_slot`, `frame_count`, `missed_count` and `irq_status` are all zero.
- R2: The engine completes only into an entry whose bit 0 was read as 0. While the current entry has bit 0 set, `buf_valid` stays low and the entry is never written.
- R3: For an owned entry at an even slot, or at any slot when `pair_mode` is 0, the engine reads descriptor word 0 at the entry value with bit 0 cleared. It reads word 1 at that address with bit 0 set. `buf_addr` then shows word 0.
- R4: Each completion writes the current entry with bit 0 = 1, bit 23 = 0, the frame count in bits 31:24 and the size in bits 22:1.
- R5: The buffer capacity is descriptor word 1 with bit 0 cleared, multiplied by two and kept to 22 bits; it appears on `buf_cap`. The written size is the smaller of `frame_bytes` and that capacity.
- R6: The frame count rises by one per completion and wraps modulo 256. The value written into the entry is the count after the increment.
- R7: `ring_slot` advances by one per completion and wraps to 0 after the last slot.
- R8: A `frame_done` that does not lead to a completion increments `missed_count`. It writes nothing and leaves `frame_count` unchanged.
- R9: `irq_status` is set when a buffer completes and is cleared by `irq_clear`. A set in the same cycle as a clear wins.
- R10: With `pair_mode` = 1, an odd slot reuses the descriptor fetched at the even slot before it. Both entries are written, and only the odd-slot completion sets `irq_status`.
- R11: `flush` returns `ring_slot` and `frame_count` to zero, drops any held buffer and suppresses a completion in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Return to slot 0 with a zero frame count |
| pair_mode | input | 1 | 1: two fields per buffer, entries used in pairs |
| ring_base | input | ADDR_W | Word address of ring slot 0 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | ADDR_W | Word address of the access |
| mem_wdata | output | 32 | Completion word to write |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| frame_done | input | 1 | One-cycle pulse: the data mover finished a field |
| frame_bytes | input | 22 | Bytes moved for that field |
| buf_valid | output | 1 | A buffer is held and ready for data |
| buf_addr | output | 32 | Address word of the held buffer |
| buf_cap | output | 22 | Capacity of the held buffer in bytes |
| irq_clear | input | 1 | Clear the latched report interrupt |
| irq_status | output | 1 | Latched report interrupt |
| ring_slot | output | RING_LOG2 | Current ring slot |
| frame_count | output | 8 | Frame counter |
| missed_count | output | MISS_W | Count of fields that found no buffer |

## Verification
The bench builds the engine with its defaults: an eight-slot ring (RING_LOG2 = 3), 32-bit addresses and a 16-bit miss counter. Eight slots are few enough that one pass of the vector table reaches the wrap back to slot 0. They also let a 256-completion run reach the frame count rollover within a short run. Eight slots still hold four buffers in paired mode. The 22-bit size field lets one vector hit the widest capacity the descriptor can express.

// File: rtl/fdr_pkg.sv
package fdr_pkg;

    localparam int WORD_W   = 32;
    localparam int FCNT_W   = 8;
    localparam int SIZE_W   = 22;

    typedef enum logic [2:0] {
        ST_ENT,   // issue read of the current ring entry
        ST_CHK,   // entry data returns; test ownership
        ST_DA,    // descriptor address word returns
        ST_DL,    // descriptor length word returns
        ST_RDY    // buffer held, waiting for a finished field
    } fdr_state_e;

    typedef struct packed {
        logic [FCNT_W-1:0] fcnt;
        logic              rsvd;
        logic [SIZE_W-1:0] size;
        logic              own;
    } done_word_t;

    function automatic logic [SIZE_W-1:0] cap_from_word(input logic [WORD_W-1:0] w);
        return {w[SIZE_W-2:1], 2'b00};
    endfunction

    function automatic logic [SIZE_W-1:0] clip_size(input logic [SIZE_W-1:0] moved,
                                                    input logic [SIZE_W-1:0] cap);
        return (moved > cap) ? cap : moved;
    endfunction

endpackage

// File: rtl/fdr_slot_ptr.sv
module fdr_slot_ptr #(
    parameter int RING_LOG2 = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 adv,
    output logic [RING_LOG2-1:0] slot
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            slot <= '0;
        end else if (adv) begin
            slot <= slot + 1'b1;
        end
    end
endmodule

// File: rtl/fdr_wrap_cnt.sv
module fdr_wrap_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (inc) begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/fdr_done_fmt.sv
module fdr_done_fmt
    import fdr_pkg::*;
(
    input  logic [FCNT_W-1:0] count_val,
    input  logic [SIZE_W-1:0] moved,
    input  logic [SIZE_W-1:0] cap,
    output logic [WORD_W-1:0] word
);
    done_word_t w;

    always_comb begin
        w.fcnt = count_val;
        w.rsvd = 1'b0;
        w.size = clip_size(moved, cap);
        w.own  = 1'b1;
        word   = w;
    end
endmodule

// File: rtl/fdr_irq_latch.sv
module fdr_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/fdr_engine.sv
module fdr_engine
    import fdr_pkg::*;
#(
    parameter int RING_LOG2 = 3,
    parameter int ADDR_W    = 32,
    parameter int MISS_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 pair_mode,
    input  logic [ADDR_W-1:0]    ring_base,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic [WORD_W-1:0]    mem_rdata,
    input  logic                 frame_done,
    input  logic [SIZE_W-1:0]    frame_bytes,
    output logic                 buf_valid,
    output logic [WORD_W-1:0]    buf_addr,
    output logic [SIZE_W-1:0]    buf_cap,
    input  logic                 irq_clear,
    output logic                 irq_status,
    output logic [RING_LOG2-1:0] ring_slot,
    output logic [FCNT_W-1:0]    frame_count,
    output logic [MISS_W-1:0]    missed_count
);
    fdr_state_e          st, st_nxt;
    logic [ADDR_W-1:0]   desc_ptr;
    logic [ADDR_W-1:0]   entry_addr;
    logic [ADDR_W-1:0]   rd_ptr;
    logic [FCNT_W-1:0]   count_next;
    logic [WORD_W-1:0]   done_word;
    logic                wr_fire;
    logic                buf_end;
    logic                reuse_desc;

    assign entry_addr = ring_base + ADDR_W'(ring_slot);
    assign rd_ptr     = ADDR_W'(mem_rdata) & ~ADDR_W'(1);
    assign reuse_desc = pair_mode && ring_slot[0];
    assign buf_valid  = (st == ST_RDY);
    assign wr_fire    = buf_valid && frame_done && !flush;
    assign buf_end    = !pair_mode || ring_slot[0];
    assign count_next = frame_count + 1'b1;

    // ring position, frame counter and miss counter
    fdr_slot_ptr #(.RING_LOG2(RING_LOG2)) u_slot (
        .clk  (clk),
        .rst  (rst),
        .flush(flush),
        .adv  (wr_fire),
        .slot (ring_slot)
    );

    fdr_wrap_cnt #(.W(FCNT_W)) u_fcnt (
        .clk(clk),
        .rst(rst),
        .clr(flush),
        .inc(wr_fire),
        .q  (frame_count)
    );

    fdr_wrap_cnt #(.W(MISS_W)) u_miss (
        .clk(clk),
        .rst(rst),
        .clr(1'b0),
        .inc(frame_done && !wr_fire),
        .q  (missed_count)
    );

    fdr_done_fmt u_fmt (
        .count_val(count_next),
        .moved    (frame_bytes),
        .cap      (buf_cap),
        .word     (done_word)
    );

    fdr_irq_latch u_irq (
        .clk(clk),
        .rst(rst),
        .set(wr_fire && buf_end),
        .clr(irq_clear),
        .q  (irq_status)
    );

    // sequencing and memory port
    always_comb begin
        st_nxt    = st;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = entry_addr;
        mem_wdata = done_word;
        unique case (st)
            ST_ENT: begin
                mem_req = 1'b1;
                st_nxt  = ST_CHK;
            end
            ST_CHK: begin
                if (mem_rdata[0]) begin
                    st_nxt = ST_ENT;
                end else if (reuse_desc) begin
                    st_nxt = ST_RDY;
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = rd_ptr;
                    st_nxt   = ST_DA;
                end
            end
            ST_DA: begin
                mem_req  = 1'b1;
                mem_addr = desc_ptr | ADDR_W'(1);
                st_nxt   = ST_DL;
            end
            ST_DL: begin
                st_nxt = ST_RDY;
            end
            ST_RDY: begin
                if (wr_fire) begin
                    mem_req = 1'b1;
                    mem_we  = 1'b1;
                    st_nxt  = ST_ENT;
                end
            end
            default: st_nxt = ST_ENT;
        endcase
        if (flush) begin
            st_nxt = ST_ENT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_ENT;
            desc_ptr <= '0;
            buf_addr <= '0;
            buf_cap  <= '0;
        end else begin
            st <= st_nxt;
            if (st == ST_CHK && !mem_rdata[0] && !reuse_desc) begin
                desc_ptr <= rd_ptr;
            end
            if (st == ST_DA) begin
                buf_addr <= mem_rdata;
            end
            if (st == ST_DL) begin
                buf_cap <= cap_from_word(mem_rdata);
            end
        end
    end
endmodule

// File: rtl/fdr_engine_chk.sv
module fdr_engine_chk
    import fdr_pkg::*;
#(
    parameter int RING_LOG2 = 3,
    parameter int MISS_W    = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 flush,
    input logic                 frame_done,
    input logic                 mem_req,
    input logic                 mem_we,
    input logic [WORD_W-1:0]    mem_wdata,
    input logic                 buf_valid,
    input logic                 irq_status,
    input logic [RING_LOG2-1:0] ring_slot,
    input logic [FCNT_W-1:0]    frame_count,
    input logic [MISS_W-1:0]    missed_count
);
    // R2: a write happens only on a finished field with a buffer held
    assert_write_owned_R2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_req && buf_valid && frame_done));

    // R4: completion word carries ownership and a zero gap bit
    assert_done_format_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata[0] && !mem_wdata[23]));

    // R6: each completion bumps the frame count by one
    assert_fcnt_step_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (frame_count == FCNT_W'($past(frame_count) + 1'b1)));

    // R7: the slot only steps forward by one or returns to zero
    assert_slot_walk_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(ring_slot) |->
            (ring_slot == RING_LOG2'($past(ring_slot) + 1'b1)) || (ring_slot == '0));

    // R8: a field with no completion is counted as missed
    assert_miss_count_R8: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !mem_we) |=>
            (missed_count == MISS_W'($past(missed_count) + 1'b1)));

    // R9: the interrupt only rises after a completion write
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_status) |-> $past(mem_we));

    // R11: flush leaves slot and count at zero and no buffer held
    assert_flush_zero_R11: assert property (@(posedge clk) disable iff (rst)
        flush |=> (ring_slot == '0 && frame_count == '0 && !buf_valid));
endmodule

bind fdr_engine fdr_engine_chk #(
    .RING_LOG2(RING_LOG2),
    .MISS_W   (MISS_W)
) u_chk (.*);

// File: tb/sim_fdr_engine.sv
module sim_fdr_engine;
    localparam int RL = 3;
    localparam int AW = 32;
    localparam int MW = 16;

    typedef struct packed {
        logic [21:0] bytes;
        logic [31:0] capw;
        logic [21:0] expect_sz;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{22'd100,      32'h0000_01F5, 22'd100},      // below capacity
        '{22'd1000,     32'h0000_01F5, 22'd1000},     // exactly capacity
        '{22'd1500,     32'h0000_01F5, 22'd1000},     // clipped
        '{22'd0,        32'h0000_0021, 22'd0},        // empty field
        '{22'd70,       32'h0000_0021, 22'd64},       // clipped small
        '{22'd4095,     32'h0000_0801, 22'd4095},     // just under
        '{22'h3F_FFFF,  32'h001F_FFFF, 22'h3F_FFFC},  // widest capacity
        '{22'd6,        32'h0000_0003, 22'd4}         // capacity rounds to 4
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush = 1'b0;
    logic          pair_mode = 1'b0;
    logic [AW-1:0] ring_base = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          frame_done = 1'b0;
    logic [21:0]   frame_bytes = '0;
    logic          buf_valid;
    logic [31:0]   buf_addr;
    logic [21:0]   buf_cap;
    logic          irq_clear = 1'b0;
    logic          irq_status;
    logic [RL-1:0] ring_slot;
    logic [7:0]    frame_count;
    logic [MW-1:0] missed_count;

    logic [31:0]   mem [0:63];
    logic          sw_we = 1'b0;
    logic [5:0]    sw_addr = '0;
    logic [31:0]   sw_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    fdr_engine #(.RING_LOG2(RL), .ADDR_W(AW), .MISS_W(MW)) u0 (
        .clk(clk), .rst(rst), .flush(flush), .pair_mode(pair_mode),
        .ring_base(ring_base), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .frame_done(frame_done), .frame_bytes(frame_bytes),
        .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_cap(buf_cap),
        .irq_clear(irq_clear), .irq_status(irq_status),
        .ring_slot(ring_slot), .frame_count(frame_count),
        .missed_count(missed_count)
    );

    // memory shared by software (bench) and the engine
    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[5:0]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[5:0]];
        if (sw_we) mem[sw_addr] <= sw_data;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sw_write(input int a, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = a[5:0]; sw_data = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    function automatic logic [31:0] bufa(input int s);
        return 32'hA000_0000 + 32'(s * 16);
    endfunction

    task automatic hand(input int s, input logic [31:0] capw);
        sw_write(32 + 2 * s, bufa(s));
        sw_write(33 + 2 * s, capw);
        sw_write(s, 32'(32 + 2 * s));
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 40 && !buf_valid; i++) @(negedge clk);
    endtask

    task automatic pulse_done(input logic [21:0] b);
        @(negedge clk);
        frame_done = 1'b1; frame_bytes = b;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    function automatic logic [31:0] done_w(input logic [7:0] f, input logic [21:0] s);
        return {f, 1'b0, s, 1'b1};
    endfunction

    initial begin
        for (int s = 0; s < 8; s++) hand(s, VEC[s].capw);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 slot", 32'(ring_slot), 32'd0);
        check("R1 fcnt", 32'(frame_count), 32'd0);
        check("R1 missed", 32'(missed_count), 32'd0);
        check("R1 irq", 32'(irq_status), 32'd0);

        // table walk: one completion per slot, R3 R4 R5 R6 R7 R9
        for (int k = 0; k < 8; k++) begin
            wait_ready();
            check("R3 buf_addr", buf_addr, bufa(k));
            check("R5 buf_cap", 32'(buf_cap), 32'((VEC[k].capw >> 1) << 2) & 32'h3F_FFFF);
            pulse_done(VEC[k].bytes);
            check("R4 R5 R6 entry", mem[k], done_w(8'(k + 1), VEC[k].expect_sz));
            check("R9 irq set", 32'(irq_status), 32'd1);
            check("R7 slot", 32'(ring_slot), 32'((k + 1) % 8));
            pulse_clear();
            check("R9 irq clear", 32'(irq_status), 32'd0);
            if (k != 0) sw_write(k, 32'(32 + 2 * k));
        end

        // slot 0 still completed (bit 0 set): stall and miss, R2 R8
        repeat (10) @(negedge clk);
        check("R2 no buffer", 32'(buf_valid), 32'd0);
        pulse_done(22'd50);
        check("R8 missed", 32'(missed_count), 32'd1);
        check("R8 fcnt held", 32'(frame_count), 32'd8);
        check("R2 entry untouched", mem[0], done_w(8'd1, 22'd100));
        hand(0, 32'h1F5);
        wait_ready();
        pulse_done(22'd200);
        check("R2 R6 after stall", mem[0], done_w(8'd9, 22'd200));

        // set and clear in one cycle: set wins, R9
        wait_ready();
        @(negedge clk);
        frame_done = 1'b1; frame_bytes = 22'd5; irq_clear = 1'b1;
        @(negedge clk);
        frame_done = 1'b0; irq_clear = 1'b0;
        check("R9 set wins", 32'(irq_status), 32'd1);
        check("R4 entry1", mem[1], done_w(8'd10, 22'd5));
        pulse_clear();

        // paired mode after flush, R10 R11
        pair_mode = 1'b1;
        hand(0, 32'h1F5);
        sw_write(1, 32'd32);
        pulse_flush();
        check("R11 slot", 32'(ring_slot), 32'd0);
        check("R11 fcnt", 32'(frame_count), 32'd0);
        check("R11 dropped", 32'(buf_valid), 32'd0);
        wait_ready();
        check("R10 buf_addr", buf_addr, bufa(0));
        pulse_done(22'd300);
        check("R10 even entry", mem[0], done_w(8'd1, 22'd300));
        check("R10 no irq on even", 32'(irq_status), 32'd0);
        sw_write(33, 32'h21);
        wait_ready();
        pulse_done(22'd400);
        check("R10 odd reuses capacity", mem[1], done_w(8'd2, 22'd400));
        check("R10 irq on odd", 32'(irq_status), 32'd1);
        check("R10 slot", 32'(ring_slot), 32'd2);
        pulse_clear();

        // frame counter rollover, R6
        pair_mode = 1'b0;
        for (int s = 0; s < 8; s++) hand(s, 32'h1F5);
        pulse_flush();
        for (int i = 0; i < 256; i++) begin
            wait_ready();
            pulse_done(22'd10);
            if (i == 254) check("R6 count ff", mem[6], done_w(8'hFF, 22'd10));
            if (i == 255) begin
                check("R6 wrap entry", mem[7], done_w(8'h00, 22'd10));
                check("R6 wrap count", 32'(frame_count), 32'd0);
            end
            sw_write(i % 8, 32'(32 + 2 * (i % 8)));
        end
        check("R8 no spurious miss", 32'(missed_count), 32'd1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule